// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

The controller counts the coins dropped into a slot and releases one product when the stored credit reaches the price. Each clock it accepts at most one coin: a nickel, a dime or a quarter. It keeps the credit in whole nickel units, from zero up to two units above the price. With the default price of 40 cents, that is 0 to 50 cents. When the credit reaches or passes the price, the controller releases the product for one cycle. In the same cycle it returns any excess as a single nickel or a single dime. On the next clock the credit drops back to zero.

A quarter can push the credit past the largest value the controller tracks. The controller does not accept that coin. It spends one cycle in a reject phase, tells the slot to give the coin back, keeps the earlier credit and then continues. All four outputs are Moore outputs: each depends only on the stored credit and on the reject phase. A build-time parameter chooses how the coin input is encoded. It is either a 2-bit binary code or a 3-bit one-hot code.

Top module: `coin_vend_fsm`

## Requirements
- R1: With the default binary coding (`ONE_HOT_COIN=0`), the 2-bit `coinCode` values map as follows: 2'b01 is a nickel (+5), 2'b10 is a dime (+10) and 2'b11 is a quarter (+25). When the credit is below 40 and the sum stays at or below 50, the coin's value is added to the credit.
- R2: `coinCode` 2'b00 means no coin. While the credit is below 40 and no reject is pending, the credit and the outputs stay unchanged.
- R3: At a credit of exactly 40, the outputs {retCoin, retNickel, retDime, releaseProduct} are 4'b0001.
- R4: At a credit of 45, the outputs are 4'b0101: the product is released and a nickel is returned.
- R5: At a credit of 50, the outputs are 4'b0011: the product is released and a dime is returned.
- R6: A quarter inserted at a credit of 30 or 35 is refused. For exactly one cycle the outputs are 4'b1000, and the coin input is ignored during that cycle. After that cycle the credit is still 30 or 35.
- R7: In the cycle after a credit of 40, 45 or 50, the credit is 0 and the outputs are 4'b0000. Any coin presented during the release cycle is ignored.
- R8: `rst` is active high and synchronous. It sets the credit to 0, leaves the reject phase and drives all outputs to 0. It takes priority over any coin input.
- R9: At every credit from 0 to 35 outside the reject phase, the outputs are 4'b0000.
- R10: With `ONE_HOT_COIN=1`, the 3-bit `coinCode` maps 3'b001 to a nickel, 3'b010 to a dime and 3'b100 to a quarter. Every other pattern, including those with several bits set, counts as no coin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coinCode | input | COIN_W (2, or 3 when one-hot) | Coin presented in this cycle |
| retCoin | output | 1 | Tell the slot to give back the coin just inserted |
| retNickel | output | 1 | Return a nickel as change |
| retDime | output | 1 | Return a dime as change |
| releaseProduct | output | 1 | Dispense one product |

## Verification
The bench builds two copies side by side. One uses the default binary coding. The other has `ONE_HOT_COIN=1` and receives the matching one-hot code in every cycle, so both decoder variants must agree cycle by cycle. The bench also sends the one-hot copy multi-bit patterns that must be treated as no coin. Both use the default price of 8 nickel units, with dime and quarter worth 2 and 5 units. This puts every coin sequence up to 50 cents in reach, including the reject entry from both 30 and 35, and a sweep of all sequences of up to eight coins is compared against a cent-level credit model.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Strobes from control to the credit datapath
  typedef struct packed {
    logic addCoin;
    logic clearCredit;
  } vendStrobe_t;

  typedef enum logic {
    PH_ACCUM  = 1'b0,
    PH_REJECT = 1'b1
  } vendPhase_t;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
  parameter int ONE_HOT_COIN  = 0,
  parameter int COIN_W        = 2,
  parameter int UNIT_W        = 3,
  parameter int DIME_UNITS    = 2,
  parameter int QUARTER_UNITS = 5
) (
  input  logic [COIN_W-1:0] coinCode,
  output logic [UNIT_W-1:0] coinUnits,
  output logic              coinHit
);

  localparam logic [UNIT_W-1:0] NICKEL_U  = UNIT_W'(1);
  localparam logic [UNIT_W-1:0] DIME_U    = UNIT_W'(DIME_UNITS);
  localparam logic [UNIT_W-1:0] QUARTER_U = UNIT_W'(QUARTER_UNITS);

  generate
    if (ONE_HOT_COIN != 0) begin : g_oneHot
      always_comb begin
        case (coinCode)
          COIN_W'(1): coinUnits = NICKEL_U;
          COIN_W'(2): coinUnits = DIME_U;
          COIN_W'(4): coinUnits = QUARTER_U;
          default:    coinUnits = '0;
        endcase
      end
    end else begin : g_binary
      always_comb begin
        case (coinCode)
          COIN_W'(1): coinUnits = NICKEL_U;
          COIN_W'(2): coinUnits = DIME_U;
          COIN_W'(3): coinUnits = QUARTER_U;
          default:    coinUnits = '0;
        endcase
      end
    end
  endgenerate

  assign coinHit = (coinUnits != '0);

endmodule

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int CREDIT_W  = 4,
  parameter int UNIT_W    = 3,
  parameter int SUM_W     = 4,
  parameter int MAX_UNITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  vendStrobe_t         strobe,
  input  logic [UNIT_W-1:0]   coinUnits,
  output logic [CREDIT_W-1:0] creditNow,
  output logic                sumOver
);

  localparam logic [SUM_W-1:0] MAX_S = SUM_W'(MAX_UNITS);

  logic [SUM_W-1:0] creditSum;

  assign creditSum = SUM_W'(creditNow) + SUM_W'(coinUnits);
  assign sumOver   = (creditSum > MAX_S);

  always_ff @(posedge clk) begin
    if (rst || strobe.clearCredit) begin
      creditNow <= '0;
    end else if (strobe.addCoin) begin
      creditNow <= CREDIT_W'(creditSum);
    end
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int CREDIT_W    = 4,
  parameter int PRICE_UNITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                coinHit,
  input  logic                sumOver,
  input  logic [CREDIT_W-1:0] creditNow,
  output vendStrobe_t         strobe,
  output logic                retCoin,
  output logic                retNickel,
  output logic                retDime,
  output logic                releaseProduct
);

  localparam logic [CREDIT_W-1:0] PRICE_C = CREDIT_W'(PRICE_UNITS);
  localparam logic [CREDIT_W-1:0] OVER_1  = CREDIT_W'(PRICE_UNITS + 1);
  localparam logic [CREDIT_W-1:0] OVER_2  = CREDIT_W'(PRICE_UNITS + 2);

  vendPhase_t phaseQ, phaseD;
  logic       atPrice;
  logic       inAccum;

  assign atPrice = (creditNow >= PRICE_C);
  assign inAccum = (phaseQ == PH_ACCUM);

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PH_ACCUM;
    else     phaseQ <= phaseD;
  end

  always_comb begin
    phaseD = PH_ACCUM;
    strobe = '0;
    if (inAccum) begin
      if (atPrice) begin
        strobe.clearCredit = 1'b1;
      end else if (coinHit) begin
        if (sumOver) phaseD = PH_REJECT;
        else         strobe.addCoin = 1'b1;
      end
    end
  end

  // Moore outputs: phase and stored credit only
  assign retCoin        = !inAccum;
  assign releaseProduct = inAccum && atPrice;
  assign retNickel      = inAccum && (creditNow == OVER_1);
  assign retDime        = inAccum && (creditNow == OVER_2);

endmodule

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm
  import vend_pkg::*;
#(
  parameter int ONE_HOT_COIN  = 0,
  parameter int PRICE_UNITS   = 8,
  parameter int DIME_UNITS    = 2,
  parameter int QUARTER_UNITS = 5,
  localparam int COIN_W       = (ONE_HOT_COIN != 0) ? 3 : 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COIN_W-1:0] coinCode,
  output logic              retCoin,
  output logic              retNickel,
  output logic              retDime,
  output logic              releaseProduct
);

  localparam int MAX_UNITS = PRICE_UNITS + 2;
  localparam int CREDIT_W  = $clog2(MAX_UNITS + 1);
  localparam int UNIT_W    = $clog2(QUARTER_UNITS + 1);
  localparam int SUM_W     = $clog2(MAX_UNITS + QUARTER_UNITS + 1);

  vendStrobe_t         strobe;
  logic [UNIT_W-1:0]   coinUnits;
  logic                coinHit;
  logic                sumOver;
  logic [CREDIT_W-1:0] creditNow;

  vend_coin_decode #(
    .ONE_HOT_COIN (ONE_HOT_COIN),
    .COIN_W       (COIN_W),
    .UNIT_W       (UNIT_W),
    .DIME_UNITS   (DIME_UNITS),
    .QUARTER_UNITS(QUARTER_UNITS)
  ) decode_i (
    .coinCode (coinCode),
    .coinUnits(coinUnits),
    .coinHit  (coinHit)
  );

  vend_datapath #(
    .CREDIT_W (CREDIT_W),
    .UNIT_W   (UNIT_W),
    .SUM_W    (SUM_W),
    .MAX_UNITS(MAX_UNITS)
  ) datapath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .coinUnits(coinUnits),
    .creditNow(creditNow),
    .sumOver  (sumOver)
  );

  vend_ctrl #(
    .CREDIT_W   (CREDIT_W),
    .PRICE_UNITS(PRICE_UNITS)
  ) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .coinHit       (coinHit),
    .sumOver       (sumOver),
    .creditNow     (creditNow),
    .strobe        (strobe),
    .retCoin       (retCoin),
    .retNickel     (retNickel),
    .retDime       (retDime),
    .releaseProduct(releaseProduct)
  );

endmodule

// File: rtl/coin_vend_fsm_chk.sv
module coin_vend_fsm_chk #(
  parameter int CREDIT_W  = 4,
  parameter int MAX_UNITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                coinHit,
  input logic [CREDIT_W-1:0] creditNow,
  input logic                retCoin,
  input logic                retNickel,
  input logic                retDime,
  input logic                releaseProduct
);

  localparam logic [CREDIT_W-1:0] MAX_C = CREDIT_W'(MAX_UNITS);

  p_credit_bound_r1: assert property (@(posedge clk) disable iff (rst)
    creditNow <= MAX_C);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!coinHit && !retCoin && !releaseProduct)
      |=> (!retCoin && !releaseProduct && $stable(creditNow)));

  p_nickel_change_r4: assert property (@(posedge clk) disable iff (rst)
    retNickel |-> (releaseProduct && !retDime && !retCoin));

  p_dime_change_r5: assert property (@(posedge clk) disable iff (rst)
    retDime |-> (releaseProduct && !retNickel && !retCoin));

  p_reject_single_r6: assert property (@(posedge clk) disable iff (rst)
    retCoin |=> (!retCoin && !releaseProduct && $stable(creditNow)));

  p_vend_clears_r7: assert property (@(posedge clk) disable iff (rst)
    releaseProduct |=> (creditNow == '0 && !releaseProduct && !retCoin));

endmodule

bind coin_vend_fsm coin_vend_fsm_chk #(
  .CREDIT_W (CREDIT_W),
  .MAX_UNITS(MAX_UNITS)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .coinHit       (coinHit),
  .creditNow     (creditNow),
  .retCoin       (retCoin),
  .retNickel     (retNickel),
  .retDime       (retDime),
  .releaseProduct(releaseProduct)
);

// File: tb/coin_vend_fsm_tb_top.sv
module coin_vend_fsm_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] codeBin = 2'b00;
  logic [2:0] codeHot = 3'b000;
  logic       rcA, rnA, rdA, rpA;
  logic       rcB, rnB, rdB, rpB;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  int  mCredit = 0;
  bit  mRej    = 1'b0;

  always #10 clk = ~clk;

  coin_vend_fsm dut_i (
    .clk(clk), .rst(rst), .coinCode(codeBin),
    .retCoin(rcA), .retNickel(rnA), .retDime(rdA), .releaseProduct(rpA)
  );

  coin_vend_fsm #(.ONE_HOT_COIN(1)) dutHot_i (
    .clk(clk), .rst(rst), .coinCode(codeHot),
    .retCoin(rcB), .retNickel(rnB), .retDime(rdB), .releaseProduct(rpB)
  );

  // {coin code, expected rc rn rd rp after the edge}, walked from reset
  localparam logic [5:0] VEC [0:22] = '{
    6'b01_0000, 6'b10_0000, 6'b00_0000, 6'b11_0001, 6'b10_0000,
    6'b11_0000, 6'b11_0011, 6'b01_0000, 6'b10_0000, 6'b10_0000,
    6'b10_0000, 6'b11_1000, 6'b01_0000, 6'b01_0000, 6'b11_1000,
    6'b11_0000, 6'b10_0101, 6'b00_0000, 6'b11_0000, 6'b01_0000,
    6'b01_0000, 6'b01_0001, 6'b01_0000
  };

  function automatic logic [2:0] toHot(input logic [1:0] c);
    case (c)
      2'b01:   return 3'b001;
      2'b10:   return 3'b010;
      2'b11:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic step(input logic r, input logic [1:0] cb, input logic [2:0] ch);
    @(negedge clk);
    rst = r; codeBin = cb; codeHot = ch;
    @(posedge clk);
    #2;
  endtask

  task automatic coin(input logic [1:0] cb);
    step(1'b0, cb, toHot(cb));
  endtask

  task automatic doReset();
    step(1'b1, 2'b00, 3'b000);
    mCredit = 0; mRej = 1'b0;
  endtask

  task automatic checkOut(input string tag, input logic [3:0] exp);
    checks++;
    if ({rcA, rnA, rdA, rpA} !== exp) begin
      fails++;
      $display("FAIL %s binary: got %b expected %b", tag, {rcA, rnA, rdA, rpA}, exp);
    end
    checks++;
    if ({rcB, rnB, rdB, rpB} !== exp) begin
      fails++;
      $display("FAIL %s one-hot: got %b expected %b", tag, {rcB, rnB, rdB, rpB}, exp);
    end
  endtask

  function automatic logic [3:0] modelOut();
    return {mRej, !mRej && mCredit == 45, !mRej && mCredit == 50, !mRej && mCredit >= 40};
  endfunction

  task automatic modelStep(input logic [1:0] c);
    int v;
    v = (c == 2'b01) ? 5 : (c == 2'b10) ? 10 : (c == 2'b11) ? 25 : 0;
    if (mRej) mRej = 1'b0;
    else if (mCredit >= 40) mCredit = 0;
    else if (v != 0) begin
      if (mCredit + v > 50) mRej = 1'b1;
      else mCredit = mCredit + v;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R8: reset state
    doReset();
    doReset();
    checkOut("R8 reset state", 4'b0000);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 23; i++) begin
      coin(VEC[i][5:4]);
      checkOut($sformatf("R1-table step %0d (R3 R4 R5 R6 R7 R9)", i), VEC[i][3:0]);
    end

    // R1 R9 sweep: every sequence of up to eight coins against the credit model
    for (int s = 0; s < 6561; s++) begin
      int rem;
      doReset();
      rem = s;
      for (int k = 0; k < 8; k++) begin
        logic [1:0] c;
        c = 2'(rem % 3 + 1);
        rem = rem / 3;
        coin(c);
        modelStep(c);
        checkOut("R1 sweep vs model (R9)", modelOut());
        if (modelOut()[0]) break;
      end
    end

    // R8: synchronous reset wins over a coin mid-credit
    doReset();
    coin(2'b11); coin(2'b10);
    checkOut("R9 credit 35 quiet", 4'b0000);
    step(1'b1, 2'b01, 3'b001);
    checkOut("R8 reset over coin", 4'b0000);
    coin(2'b11); checkOut("R8 after reset 25", 4'b0000);
    coin(2'b10); checkOut("R8 after reset 35", 4'b0000);
    coin(2'b01); checkOut("R8 after reset 40", 4'b0001);

    // R2: long idle keeps credit
    doReset();
    coin(2'b10); coin(2'b10);
    for (int i = 0; i < 5; i++) begin
      coin(2'b00);
      checkOut("R2 idle hold", 4'b0000);
    end
    coin(2'b10); checkOut("R2 credit kept 30", 4'b0000);
    coin(2'b10); checkOut("R3 vend at 40 after idle", 4'b0001);

    // R6: coin during reject phase is ignored, credit kept
    doReset();
    coin(2'b11); coin(2'b01);
    coin(2'b11); checkOut("R6 reject from 30", 4'b1000);
    coin(2'b10); checkOut("R6 dime ignored in reject", 4'b0000);
    coin(2'b01); checkOut("R6 credit back to 35", 4'b0000);
    coin(2'b01); checkOut("R6 vend at 40", 4'b0001);

    // R7: coin during release cycle is ignored
    doReset();
    coin(2'b11); coin(2'b10); coin(2'b10);
    checkOut("R4 vend with nickel", 4'b0101);
    coin(2'b11); checkOut("R7 quarter ignored at release", 4'b0000);
    for (int i = 0; i < 3; i++) begin
      coin(2'b10); checkOut("R7 credit restarted", 4'b0000);
    end
    coin(2'b10); checkOut("R7 vend only at 40", 4'b0001);

    // R10: malformed one-hot patterns are no coin
    doReset();
    coin(2'b10);
    step(1'b0, 2'b00, 3'b011); checkOut("R10 pattern 011", 4'b0000);
    step(1'b0, 2'b00, 3'b110); checkOut("R10 pattern 110", 4'b0000);
    step(1'b0, 2'b00, 3'b111); checkOut("R10 pattern 111", 4'b0000);
    step(1'b0, 2'b00, 3'b101); checkOut("R10 pattern 101", 4'b0000);
    coin(2'b10); checkOut("R10 credit 20", 4'b0000);
    coin(2'b10); checkOut("R10 credit 30", 4'b0000);
    coin(2'b10); checkOut("R10 vend at 40", 4'b0001);

    // R5: dime change at 50
    doReset();
    coin(2'b11); coin(2'b11);
    checkOut("R5 vend with dime", 4'b0011);
    coin(2'b00); checkOut("R7 back to zero", 4'b0000);

    finishRun();
  end

endmodule